// File: doc/BRIEF.md
# Pin-Selectable Level Interrupt Router

The router turns levels on a wide bank of general-purpose pins into one interrupt line. It has eight slots. Each slot watches one pin, and each slot is programmed with a trigger code and a source selector. The selector picks a group of eight pins, and slot n always takes bit n of that group. A group is one byte of one port, so the selector value is the byte number plus four times the port number. When a slot's mask bit is set and its pin shows the programmed level, the slot latches a pending flag. That flag stays set until software acknowledges it.

A small register file sits on a simple write-strobe and combinational-read bus. It holds the trigger codes, the selectors and the mask. It also has a write-one acknowledge register and a read-only status word. The status word shows the pending flags ANDed with the mask. It also shows two auxiliary level interrupts that share the mask register but do not use slots. The OR of the status word is registered and drives the single interrupt output.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads zero, the status word is zero and `irq_o` is low.
- R2: Register offsets on `addr_i`: 0 holds the trigger codes (24 bits), 1 holds the selectors (32 bits), 2 holds the mask (10 bits), 3 is the acknowledge register and always reads 0, and 4 is the status word, which writes do not change. Offsets 5 to 7 read 0. Bits above each register's width read 0.
- R3: The trigger code of slot n sits in bits 3n+2..3n. Code 1 makes the slot fire while its pin is high. Code 2 makes it fire while its pin is low.
- R4: Code 0 and codes 3 to 7 disable a slot, and a disabled slot never becomes pending.
- R5: The selector of slot n sits in bits 4n+3..4n. For a selector value s, the source of slot n is `pins_i[(s/4)*32 + (s%4)*8 + n]`.
- R6: A slot becomes pending on the clock edge after its mask bit is set and its pin matches. It does not become pending while its mask bit is clear. Once pending, it stays pending after the pin level goes away.
- R7: Writing 1 to bit n of the acknowledge register clears pending flag n at that write's edge. Acknowledge takes priority over a new match. If the level is still present, the flag sets again on the following edge.
- R8: Status bits 7..0 show the pending flags ANDed with mask bits 7..0. Clearing a mask bit hides a pending flag without clearing it.
- R9: Status bits 9..8 show `aux_irq_i` ANDed with mask bits 9..8. They follow the level with no latching, and acknowledge bits 9..8 have no effect on them.
- R10: `irq_o` is the OR of the status word, delayed by one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 128 | Synchronised pins of four 32-bit ports, port 0 in the low bits |
| aux_irq_i | input | 2 | Two auxiliary level interrupt sources |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
A wrong selector decode or trigger decode shows in the status word one edge after the slot is armed, because a pending flag is set only from the programmed pin. The sweep arms all slots with each of the sixteen selectors and both levels, so a single misrouted bit is caught. A wrong priority between acknowledge and match shows right after the acknowledge edge: the status bit must read 0 there and 1 one edge later. A missing or extra pipeline stage on the interrupt output shows as `irq_o` changing one edge too early or too late.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2
  } trig_e;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_SEL  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_ACK  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned MODE_W    = 3,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned AUX_W     = 2,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [NUM_SLOTS+AUX_W-1:0]       status_i,
  output logic [NUM_SLOTS*MODE_W-1:0]      cfg_o,
  output logic [NUM_SLOTS*SEL_W-1:0]       sel_o,
  output logic [NUM_SLOTS+AUX_W-1:0]       mask_o,
  output logic [NUM_SLOTS-1:0]             ack_o,
  output logic [DATA_W-1:0]                rdata_o
);
  localparam int unsigned CFG_W  = NUM_SLOTS * MODE_W;
  localparam int unsigned SELT_W = NUM_SLOTS * SEL_W;
  localparam int unsigned MASK_W = NUM_SLOTS + AUX_W;

  logic [CFG_W-1:0]  cfg_q;
  logic [SELT_W-1:0] sel_q;
  logic [MASK_W-1:0] mask_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      sel_q  <= '0;
      mask_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFF_CFG:  cfg_q  <= wdata_i[CFG_W-1:0];
        OFF_SEL:  sel_q  <= wdata_i[SELT_W-1:0];
        OFF_MASK: mask_q <= wdata_i[MASK_W-1:0];
        default: ;
      endcase
    end
  end

  // acknowledge is a single-cycle strobe, never stored
  assign ack_o = (wr_i && addr_i == OFF_ACK) ? wdata_i[NUM_SLOTS-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CFG:  rdata_o[CFG_W-1:0]  = cfg_q;
      OFF_SEL:  rdata_o[SELT_W-1:0] = sel_q;
      OFF_MASK: rdata_o[MASK_W-1:0] = mask_q;
      OFF_STAT: rdata_o[MASK_W-1:0] = status_i;
      default: ;
    endcase
  end

  assign cfg_o  = cfg_q;
  assign sel_o  = sel_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_router_slot.sv
module irq_router_slot
  import irq_router_pkg::*;
#(
  parameter int unsigned GROUPS = 16,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GROUPS-1:0] grp_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [2:0]        mode_i,
  input  logic              mask_i,
  input  logic              ack_i,
  output logic              pend_o
);
  logic src;
  logic hit;
  logic pend_q;

  if (GROUPS == (1 << SEL_W)) begin : g_full
    assign src = grp_i[sel_i];
  end else begin : g_part
    assign src = (32'(sel_i) < GROUPS) ? grp_i[sel_i] : 1'b0;
  end

  always_comb begin
    case (mode_i)
      TRIG_HIGH: hit = src;
      TRIG_LOW:  hit = ~src;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (ack_i)  pend_q <= 1'b0;
    else             pend_q <= pend_q | (mask_i & hit);
  end

  assign pend_o = pend_q;

  // R7
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !pend_o);
  // R6
  pend_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(mask_i && hit));
  // R6
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !ack_i) |=> pend_o);
  // R4
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_o && mode_i != TRIG_HIGH && mode_i != TRIG_LOW) |=> !pend_o);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 32,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned AUX_W     = 2,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS*PORT_W-1:0] pins_i,
  input  logic [AUX_W-1:0]            aux_irq_i,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        irq_o
);
  localparam int unsigned MODE_W = 3;
  localparam int unsigned GROUPS = NUM_PORTS * PORT_W / NUM_SLOTS;
  localparam int unsigned SEL_W  = $clog2(GROUPS);
  localparam int unsigned MASK_W = NUM_SLOTS + AUX_W;

  logic [NUM_SLOTS*MODE_W-1:0] cfg;
  logic [NUM_SLOTS*SEL_W-1:0]  sel;
  logic [MASK_W-1:0]           mask;
  logic [NUM_SLOTS-1:0]        ack;
  logic [NUM_SLOTS-1:0]        pend;
  logic [MASK_W-1:0]           status;
  logic                        irq_q;

  irq_router_regs #(
    .NUM_SLOTS(NUM_SLOTS), .MODE_W(MODE_W), .SEL_W(SEL_W),
    .AUX_W(AUX_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .status_i(status), .cfg_o(cfg), .sel_o(sel), .mask_o(mask),
    .ack_o(ack), .rdata_o
  );

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    logic [GROUPS-1:0] grp;
    // slot n sees bit n of every byte group
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign grp[g] = pins_i[g*NUM_SLOTS + n];
    end
    irq_router_slot #(.GROUPS(GROUPS), .SEL_W(SEL_W)) u_slot (
      .clk_i, .rst_ni,
      .grp_i (grp),
      .sel_i (sel[n*SEL_W +: SEL_W]),
      .mode_i(cfg[n*MODE_W +: MODE_W]),
      .mask_i(mask[n]),
      .ack_i (ack[n]),
      .pend_o(pend[n])
    );
  end

  assign status = {aux_irq_i & mask[MASK_W-1:NUM_SLOTS], pend & mask[NUM_SLOTS-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |status;
  end

  assign irq_o = irq_q;

  // R10
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status) |=> irq_o);
  // R10
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|status) |=> !irq_o);
  // R9
  aux_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[MASK_W-1:NUM_SLOTS] == (aux_irq_i & mask[MASK_W-1:NUM_SLOTS]));
endmodule

// File: tb/gpio_irq_router_test.sv
`timescale 1ns/1ps
module gpio_irq_router_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] pins = '0;
  logic [1:0]   aux = '0;
  logic         wr = 1'b0;
  logic [2:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq;
  int           n_run = 0;
  int           n_fail = 0;

  always #2 clk = ~clk;

  gpio_irq_router uut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .aux_irq_i(aux),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [127:0] pat(input int seed);
    logic [127:0] p;
    for (int i = 0; i < 128; i++) p[i] = ((i * 5 + seed * 3) % 7) < 3;
    return p;
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(3'd0, d); chk("R1 cfg", d, 0);
    rd_reg(3'd2, d); chk("R1 mask", d, 0);
    rd_reg(3'd4, d); chk("R1 status", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 register map and widths
    wr_reg(3'd0, 32'hFFFF_FFFF); rd_reg(3'd0, d); chk("R2 cfg width", d, 32'h00FF_FFFF);
    wr_reg(3'd1, 32'hA5C3_1E7B); rd_reg(3'd1, d); chk("R2 sel", d, 32'hA5C3_1E7B);
    wr_reg(3'd2, 32'hFFFF_FFFF); rd_reg(3'd2, d); chk("R2 mask width", d, 32'h0000_03FF);
    wr_reg(3'd3, 32'h0000_0000); rd_reg(3'd3, d); chk("R2 ack reads 0", d, 0);
    wr_reg(3'd4, 32'hFFFF_FFFF); rd_reg(3'd4, d); chk("R2 status write ignored", d, 0);
    for (int a = 5; a < 8; a++) begin
      rd_reg(3'(a), d); chk("R2 unmapped", d, 0);
    end
    wr_reg(3'd2, 32'h0);

    // R3 R5 sweep: every selector, both levels
    wr_reg(3'd2, 32'hFF);
    for (int lv = 1; lv <= 2; lv++) begin
      wr_reg(3'd0, {8'd0, {8{3'(lv)}}});
      for (int s = 0; s < 16; s++) begin
        pins = pat(s + lv * 16);
        wr_reg(3'd1, {8{4'(s)}});
        wr_reg(3'd3, 32'hFF);
        tick();
        for (int n = 0; n < 8; n++) begin
          e[n] = pins[(s / 4) * 32 + (s % 4) * 8 + n];
          if (lv == 2) e[n] = ~e[n];
        end
        rd_reg(3'd4, d);
        chk(lv == 1 ? "R3 R5 high sweep" : "R3 R5 low sweep", d, {24'd0, e});
      end
    end

    // R5 distinct selector per slot (slot n uses group 8+n)
    pins = pat(99);
    wr_reg(3'd0, {8'd0, {8{3'd1}}});
    wr_reg(3'd1, 32'hFEDC_BA98);
    wr_reg(3'd3, 32'hFF);
    tick();
    for (int n = 0; n < 8; n++) e[n] = pins[((8 + n) / 4) * 32 + ((8 + n) % 4) * 8 + n];
    rd_reg(3'd4, d); chk("R5 per-slot select", d, {24'd0, e});

    // R4 disabled codes
    for (int m = 0; m < 8; m++) begin
      if (m == 1 || m == 2) continue;
      wr_reg(3'd0, {8'd0, {8{3'(m)}}});
      for (int pv = 0; pv < 2; pv++) begin
        pins = pv ? '1 : '0;
        wr_reg(3'd3, 32'hFF);
        tick(); tick();
        rd_reg(3'd4, d); chk("R4 disabled code", d, 0);
      end
    end

    // R6 mask gating and latching
    wr_reg(3'd1, 32'h0);
    wr_reg(3'd0, {8'd0, {8{3'd1}}});
    wr_reg(3'd2, 32'h0);
    pins = '1;
    wr_reg(3'd3, 32'hFF);
    tick(); tick();
    pins = '0;
    wr_reg(3'd2, 32'hFF);
    tick();
    rd_reg(3'd4, d); chk("R6 no pend while masked", d, 0);
    pins[0] = 1'b1;
    tick();
    pins[0] = 1'b0;
    tick();
    rd_reg(3'd4, d); chk("R6 latched after level gone", d, 32'h1);

    // R8 mask hides, does not clear
    wr_reg(3'd2, 32'h0);
    rd_reg(3'd4, d); chk("R8 hidden", d, 0);
    wr_reg(3'd2, 32'hFF);
    rd_reg(3'd4, d); chk("R8 kept", d, 32'h1);

    // R7 acknowledge
    wr_reg(3'd3, 32'h1);
    rd_reg(3'd4, d); chk("R7 ack clears", d, 0);
    tick();
    rd_reg(3'd4, d); chk("R7 stays clear without level", d, 0);
    pins[0] = 1'b1;
    tick();
    wr_reg(3'd3, 32'h1);
    rd_reg(3'd4, d); chk("R7 ack wins over match", d, 0);
    tick();
    rd_reg(3'd4, d); chk("R7 re-asserts", d, 32'h1);
    pins = '0;
    wr_reg(3'd3, 32'hFF);

    // R9 auxiliary bits
    for (int mk = 0; mk < 4; mk++) begin
      wr_reg(3'd2, {22'd0, 2'(mk), 8'd0});
      for (int av = 0; av < 4; av++) begin
        aux = 2'(av);
        rd_reg(3'd4, d); chk("R9 aux level", d, {22'd0, 2'(mk & av), 8'd0});
      end
    end
    aux = 2'b11;
    wr_reg(3'd3, 32'h300);
    rd_reg(3'd4, d); chk("R9 ack ignored", d, 32'h300);
    aux = 2'b00;
    wr_reg(3'd2, 32'h0);
    tick();

    // R10 registered interrupt
    pins = '1;
    chk("R10 idle", {31'd0, irq}, 0);
    wr_reg(3'd2, 32'h01);
    chk("R10 low before pend", {31'd0, irq}, 0);
    tick();
    rd_reg(3'd4, d); chk("R10 status set", d, 32'h1);
    chk("R10 one stage late", {31'd0, irq}, 0);
    tick();
    chk("R10 high", {31'd0, irq}, 1);
    wr_reg(3'd2, 32'h0);
    chk("R10 still high", {31'd0, irq}, 1);
    tick();
    chk("R10 falls", {31'd0, irq}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule